// File: doc/BRIEF.md
# Elastic Buffer Delay Monitor

This block reports how far the write side of a receive elastic buffer runs ahead of the read side. The distance is measured in whole 8-bit time slots. The block takes the write and read bit positions of the buffer and a bit-clock enable. On each enabled bit it advances a period counter. When the counter reaches one frame period (193 bits) or two frame periods (386 bits), it latches the pointer distance into a 6-bit status value. The selected period depends on a buffer-size setting. Distances beyond the field's range saturate at the top code.

A host that wants a consistent reading first pulses a freeze command, which stops further updates. It then reads the value, and the read strobe lets periodic updates resume. While the buffer is bypassed, the valid flag is low and the held value does not change.

Top module: `ebuf_delay_mon`

## Requirements
- R1: After reset `delay_o` is 0 and `valid_o` is 0.
- R2: At an update, `delay_o` becomes floor(D / 8), where D = (`wr_pos_i` - `rd_pos_i`) modulo BUF_BITS, the buffer length in bits (772 by default). A distance under 8 bits gives 0.
- R3: When D / 8 exceeds 63, `delay_o` saturates at 63. A distance of 503 bits gives 62, and 504 bits or more gives 63.
- R4: With `two_frame_i` = 0, an update happens on every 193rd cycle that has `bit_en_i` high. Cycles with `bit_en_i` low do not advance the count. `delay_o` changes only at an update.
- R5: With `two_frame_i` = 1, an update happens on every 386th enabled bit instead.
- R6: A one-cycle pulse on `freeze_i` blocks every later update, including one due in the same cycle, until a read releases it.
- R7: A pulse on `rd_i` releases a freeze. The next period end then updates `delay_o`.
- R8: When `freeze_i` and `rd_i` are high in the same cycle, the block ends up frozen.
- R9: While `bypass_i` is high, `valid_o` is 0 and no update happens. When bypass drops, `valid_o` returns high with the held value, provided an update had occurred before.
- R10: `valid_o` first goes high at the first update after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | One buffer bit passes in this cycle |
| wr_pos_i | input | 10 | Write bit position in the buffer |
| rd_pos_i | input | 10 | Read bit position in the buffer |
| two_frame_i | input | 1 | 0: update every 193 bits, 1: every 386 bits |
| freeze_i | input | 1 | Host freeze command pulse |
| rd_i | input | 1 | Host read strobe, releases freeze |
| bypass_i | input | 1 | Elastic buffer bypassed |
| delay_o | output | 6 | Buffer delay in time slots |
| valid_o | output | 1 | Delay value is meaningful |

## Verification
The assertions assume that `bit_en_i`, `freeze_i`, `rd_i` and `bypass_i` are synchronous and settled before each rising edge. They also assume that both positions stay below the buffer length. The bench keeps every pointer value under 772 and drives all inputs on the falling edge. It issues host commands only in cycles where `bit_en_i` is low. It changes the period select only right after an update, so the expected update cycle is never ambiguous.

// File: rtl/ebdm_pkg.sv
package ebdm_pkg;
  typedef enum logic {
    PER_ONE_FRAME = 1'b0,
    PER_TWO_FRAME = 1'b1
  } per_sel_e;
endpackage

// File: rtl/ebdm_period_timer.sv
module ebdm_period_timer
  import ebdm_pkg::*;
#(
  parameter int FRAME_BITS = 193
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     bit_en_i,
  input  per_sel_e sel_i,
  output logic     tick_o
);
  localparam int CNT_W = $clog2(2 * FRAME_BITS);
  localparam logic [CNT_W-1:0] LIM_ONE = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] LIM_TWO = CNT_W'(2 * FRAME_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit  = (sel_i == PER_TWO_FRAME) ? LIM_TWO : LIM_ONE;
  // >= so a shrinking period still terminates
  assign tick_o = bit_en_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else if (bit_en_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ebdm_delay_calc.sv
module ebdm_delay_calc #(
  parameter int PTR_W     = 10,
  parameter int BUF_BITS  = 772,
  parameter int SLOT_BITS = 8,
  parameter int DELAY_W   = 6
) (
  input  logic [PTR_W-1:0]   wr_pos_i,
  input  logic [PTR_W-1:0]   rd_pos_i,
  output logic [DELAY_W-1:0] delay_o
);
  localparam int SHIFT = $clog2(SLOT_BITS);
  localparam logic [PTR_W:0] BUF_LEN = (PTR_W+1)'(BUF_BITS);
  localparam logic [DELAY_W-1:0] MAX_CODE = '1;
  localparam logic [PTR_W:0] MAX_WIDE = {{(PTR_W+1-DELAY_W){1'b0}}, MAX_CODE};

  logic [PTR_W:0] diff;
  logic [PTR_W:0] slots;

  always_comb begin
    if (wr_pos_i >= rd_pos_i) diff = {1'b0, wr_pos_i} - {1'b0, rd_pos_i};
    else                      diff = {1'b0, wr_pos_i} + BUF_LEN - {1'b0, rd_pos_i};
    slots = diff >> SHIFT;
    if (slots > MAX_WIDE) delay_o = MAX_CODE;
    else                  delay_o = slots[DELAY_W-1:0];
  end
endmodule

// File: rtl/ebdm_hold.sv
module ebdm_hold #(
  parameter int DELAY_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               freeze_i,
  input  logic               rd_i,
  input  logic               bypass_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic [DELAY_W-1:0] delay_o,
  output logic               valid_o
);
  logic               frozen_q;
  logic               seen_q;
  logic [DELAY_W-1:0] delay_q;
  logic               upd;

  assign upd = tick_i && !frozen_q && !freeze_i && !bypass_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      seen_q   <= 1'b0;
      delay_q  <= '0;
    end else begin
      if (freeze_i)  frozen_q <= 1'b1;  // freeze beats read
      else if (rd_i) frozen_q <= 1'b0;
      if (upd) begin
        delay_q <= delay_i;
        seen_q  <= 1'b1;
      end
    end
  end

  assign delay_o = delay_q;
  assign valid_o = seen_q && !bypass_i;
endmodule

// File: rtl/ebuf_delay_mon.sv
module ebuf_delay_mon
  import ebdm_pkg::*;
#(
  parameter int PTR_W      = 10,
  parameter int BUF_BITS   = 772,
  parameter int FRAME_BITS = 193,
  parameter int SLOT_BITS  = 8,
  parameter int DELAY_W    = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic [PTR_W-1:0]   wr_pos_i,
  input  logic [PTR_W-1:0]   rd_pos_i,
  input  logic               two_frame_i,
  input  logic               freeze_i,
  input  logic               rd_i,
  input  logic               bypass_i,
  output logic [DELAY_W-1:0] delay_o,
  output logic               valid_o
);
  logic               tick;
  logic [DELAY_W-1:0] calc;
  per_sel_e           sel;

  assign sel = per_sel_e'(two_frame_i);

  ebdm_period_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .sel_i(sel), .tick_o(tick)
  );

  ebdm_delay_calc #(
    .PTR_W(PTR_W), .BUF_BITS(BUF_BITS), .SLOT_BITS(SLOT_BITS), .DELAY_W(DELAY_W)
  ) u_calc (
    .wr_pos_i(wr_pos_i), .rd_pos_i(rd_pos_i), .delay_o(calc)
  );

  ebdm_hold #(.DELAY_W(DELAY_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .freeze_i(freeze_i),
    .rd_i(rd_i), .bypass_i(bypass_i), .delay_i(calc),
    .delay_o(delay_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/ebuf_delay_mon_chk.sv
module ebuf_delay_mon_chk #(
  parameter int DELAY_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bit_en_i,
  input logic               freeze_i,
  input logic               rd_i,
  input logic               bypass_i,
  input logic [DELAY_W-1:0] delay_o,
  input logic               valid_o
);
  // delay only moves after an enabled bit
  assert_change_on_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(delay_o) |-> $past(bit_en_i));

  assert_freeze_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(delay_o));

  assert_freeze_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && rd_i) |=> $stable(delay_o));

  assert_bypass_invalid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> !valid_o);

  assert_bypass_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> $stable(delay_o));

  assert_valid_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> !bypass_i);
endmodule

bind ebuf_delay_mon ebuf_delay_mon_chk #(.DELAY_W(DELAY_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .freeze_i(freeze_i),
  .rd_i(rd_i), .bypass_i(bypass_i), .delay_o(delay_o), .valid_o(valid_o)
);

// File: tb/ebuf_delay_mon_bench.sv
`timescale 1ns/1ps
module ebuf_delay_mon_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic [9:0] wr_pos = '0;
  logic [9:0] rd_pos = '0;
  logic       two_frame = 1'b0;
  logic       freeze = 1'b0;
  logic       rd = 1'b0;
  logic       bypass = 1'b0;
  logic [5:0] delay;
  logic       valid;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ebuf_delay_mon u_ebuf_delay_mon (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .wr_pos_i(wr_pos),
    .rd_pos_i(rd_pos), .two_frame_i(two_frame), .freeze_i(freeze), .rd_i(rd),
    .bypass_i(bypass), .delay_o(delay), .valid_o(valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // n cycles with given enable, ends at a falling edge
  task automatic run(input int n, input logic en);
    for (int i = 0; i < n; i++) begin
      bit_en = en;
      @(posedge clk);
      @(negedge clk);
    end
    bit_en = 1'b0;
  endtask

  task automatic pulse(input logic f, input logic r);
    freeze = f; rd = r;
    @(posedge clk);
    @(negedge clk);
    freeze = 1'b0; rd = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 delay", delay, 0);
    chk("R1 valid", valid, 0);
  endtask

  task automatic t_basic;
    wr_pos = 10'd100; rd_pos = 10'd20;
    run(192, 1'b1);
    chk("R4 no early update", delay, 0);
    chk("R10 valid still low", valid, 0);
    run(1, 1'b1);
    chk("R2 basic", delay, 10);
    chk("R10 valid high", valid, 1);
  endtask

  task automatic t_gap;
    wr_pos = 10'd200; rd_pos = 10'd0;
    run(100, 1'b1);
    run(60, 1'b0);
    run(92, 1'b1);
    chk("R4 idle bits ignored", delay, 10);
    run(1, 1'b1);
    chk("R4 update at 193rd bit", delay, 25);
  endtask

  task automatic t_wrap;
    wr_pos = 10'd5; rd_pos = 10'd700;
    run(193, 1'b1);
    chk("R2 wrap", delay, 9);
    wr_pos = 10'd7; rd_pos = 10'd0;
    run(193, 1'b1);
    chk("R2 below one slot", delay, 0);
  endtask

  task automatic t_sat;
    wr_pos = 10'd503; rd_pos = 10'd0;
    run(193, 1'b1);
    chk("R3 503 bits", delay, 62);
    wr_pos = 10'd504;
    run(193, 1'b1);
    chk("R3 504 bits", delay, 63);
    wr_pos = 10'd771;
    run(193, 1'b1);
    chk("R3 far above", delay, 63);
  endtask

  task automatic t_mode;
    two_frame = 1'b1;
    wr_pos = 10'd300; rd_pos = 10'd0;
    run(385, 1'b1);
    chk("R5 no update at 385", delay, 63);
    run(1, 1'b1);
    chk("R5 update at 386", delay, 37);
    two_frame = 1'b0;
  endtask

  task automatic t_freeze;
    pulse(1'b1, 1'b0);
    wr_pos = 10'd400;
    run(386, 1'b1);
    chk("R6 frozen", delay, 37);
    pulse(1'b0, 1'b1);
    chk("R7 read keeps value", delay, 37);
    run(193, 1'b1);
    chk("R7 resumed", delay, 50);
  endtask

  task automatic t_both;
    pulse(1'b1, 1'b1);
    wr_pos = 10'd80;
    run(193, 1'b1);
    chk("R8 freeze wins", delay, 50);
    pulse(1'b0, 1'b1);
    run(193, 1'b1);
    chk("R7 release after R8", delay, 10);
  endtask

  task automatic t_bypass;
    bypass = 1'b1;
    #1;
    chk("R9 valid low", valid, 0);
    wr_pos = 10'd160;
    run(193, 1'b1);
    chk("R9 value held", delay, 10);
    chk("R9 valid stays low", valid, 0);
    bypass = 1'b0;
    #1;
    chk("R9 valid back", valid, 1);
    chk("R9 held after bypass", delay, 10);
    run(193, 1'b1);
    chk("R9 updates again", delay, 20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_gap();
    t_wrap();
    t_sat();
    t_mode();
    t_freeze();
    t_both();
    t_bypass();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule